// File: doc/BRIEF.md
# Compressed Instruction Trace Port Encoder

This block sits next to a scalar 32-bit processor pipeline and turns its per-cycle retirement activity into a narrow trace stream: one clock output and a 7-bit data bus. The external collector samples that stream continuously. For sequential code only a per-cycle status is sent, because the next address is always the previous one plus 4. When the flow jumps to a branch or exception target, the full 32-bit target is serialized on five dedicated address lanes over seven cycles. With that, a reconstruction tool can rebuild every executed address.

The data bus carries a 2-bit status field in bits [6:5] and a 5-bit address lane in bits [4:0]. The encoder has no input back to the pipeline and never stalls it. A trigger pulse is folded into the stream as a marker. A newer jump that arrives while an older target is still being sent restarts the serialization and raises a sticky overflow flag. A global enable blanks the whole data bus.

Top module: `trace_port_enc`

## Requirements
- R1: `tp_clk` always equals the core clock `clk`, whether tracing is enabled or not and during reset.
- R2: A completion without a discontinuity (`retire`=1, `redirect`=0) while enabled produces status bits [6:5]=2'b01 after the next rising edge.
- R3: A cycle with no completion (`retire`=0) while enabled produces status 2'b00 after the next rising edge, unless a trigger marker is due. `redirect` is ignored when `retire`=0, so no 2'b10 status appears and no address lane activity starts.
- R4: A completion with a discontinuity (`retire`=1, `redirect`=1) produces status 2'b10 after the next edge. In that same output cycle, lane bits [4:0] hold target bits [31:27]. The following six cycles hold bits [26:22], [21:17], [16:12], [11:7], [6:2], and then {bits[1:0], 3'b000}. After that the lane returns to zero.
- R5: A trigger pulse produces status 2'b11 in the first output cycle, at or after the pulse, whose own input cycle has no completion. Completions that occur before that cycle keep their codes 2'b01 or 2'b10.
- R6: A discontinuity accepted while slots of an earlier target are still unsent restarts the lane sequence with the new target and sets `ovf_flag`. A discontinuity accepted seven or more cycles after the previous one does not set the flag. The flag stays set until an `ovf_clr` pulse clears it.
- R7: While `trace_en` is sampled low, `tp_data` is all zeros after the next edge. Any serialization in progress and any pending trigger marker are discarded.
- R8: After reset, `tp_data` is zero and `ovf_flag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Enables the trace stream |
| retire | input | 1 | An instruction completed this cycle |
| redirect | input | 1 | The completing instruction is a taken branch or exception target |
| redirect_addr | input | 32 | Address of the discontinuity target |
| trig | input | 1 | Trigger pulse from debug logic |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tp_clk | output | 1 | Trace synchronizing clock |
| tp_data | output | 7 | Status [6:5] and address lane [4:0] |
| ovf_flag | output | 1 | Sticky flag: a target serialization was cut short |

## Verification
The bench builds the encoder with its default widths: a 32-bit address and a 5-bit lane. That gives seven slots, the last of which carries three pad bits, so the zero-padded final slot can be observed directly. The same values place the overflow boundary at a seven-cycle spacing between jumps, which the bench probes on both sides: exactly seven cycles, and two cycles. The trigger tests cover the deferred marker behind back-to-back completions, and the disable tests show a half-sent address and a pending marker being dropped.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEQ  = 2'b01,
    ST_TGT  = 2'b10,
    ST_TRIG = 2'b11
  } tstat_e;

  // Completion codes win over the trigger marker, which waits for an idle slot.
  function automatic tstat_e pick_status(logic ret, logic redir, logic trg_any);
    if (ret && redir)  return ST_TGT;
    else if (ret)      return ST_SEQ;
    else if (trg_any)  return ST_TRIG;
    else               return ST_IDLE;
  endfunction

  function automatic int unsigned slot_count(int unsigned aw, int unsigned lw);
    return (aw + lw - 1) / lw;
  endfunction

endpackage

// File: rtl/trace_status_unit.sv
module trace_status_unit
  import trace_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       retire,
  input  logic       redirect,
  input  logic       trig,
  output logic [1:0] stat_q,
  output logic       trig_pend
);

  tstat_e code_d;

  always_comb begin
    code_d = pick_status(retire, redirect, trig | trig_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= 2'b00;
      trig_pend <= 1'b0;
    end else if (!en) begin
      stat_q    <= 2'b00;
      trig_pend <= 1'b0;
    end else begin
      stat_q    <= code_d;
      trig_pend <= (code_d == ST_TRIG) ? 1'b0 : (trig_pend | trig);
    end
  end

endmodule

// File: rtl/trace_addr_serializer.sv
module trace_addr_serializer #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ovf_clr,
  output logic [LANE_W-1:0] lane_q,
  output logic              ovf_q,
  output logic              restart_hit
);

  localparam int NSLOTS = trace_pkg::slot_count(ADDR_W, LANE_W);
  localparam int SH_W   = NSLOTS * LANE_W;
  localparam int PAD    = SH_W - ADDR_W;
  localparam int CNT_W  = $clog2(NSLOTS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSLOTS - 1);

  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  padded;
  logic [CNT_W-1:0] rem_q;

  assign padded      = SH_W'(addr) << PAD;
  assign restart_hit = en && start && (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
    end else if (!en) begin
      lane_q <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
    end else if (start) begin
      lane_q <= padded[SH_W-1 -: LANE_W];
      sh_q   <= padded << LANE_W;
      rem_q  <= LAST;
    end else if (rem_q != '0) begin
      lane_q <= sh_q[SH_W-1 -: LANE_W];
      sh_q   <= sh_q << LANE_W;
      rem_q  <= rem_q - 1'b1;
    end else begin
      lane_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovf_q <= 1'b0;
    else if (restart_hit) ovf_q <= 1'b1;
    else if (ovf_clr)     ovf_q <= 1'b0;
  end

endmodule

// File: rtl/trace_port_enc.sv
module trace_port_enc #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 5,
  parameter int STAT_W = 2,
  localparam int DATA_W = STAT_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              retire,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              trig,
  input  logic              ovf_clr,
  output logic              tp_clk,
  output logic [DATA_W-1:0] tp_data,
  output logic              ovf_flag
);

  logic [STAT_W-1:0] stat_q;
  logic [LANE_W-1:0] lane_q;
  logic              trig_pend;
  logic              restart_hit;
  logic              tgt_start;

  assign tp_clk    = clk;
  assign tgt_start = retire & redirect;

  trace_status_unit u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (trace_en),
    .retire    (retire),
    .redirect  (redirect),
    .trig      (trig),
    .stat_q    (stat_q),
    .trig_pend (trig_pend)
  );

  trace_addr_serializer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (trace_en),
    .start       (tgt_start),
    .addr        (redirect_addr),
    .ovf_clr     (ovf_clr),
    .lane_q      (lane_q),
    .ovf_q       (ovf_flag),
    .restart_hit (restart_hit)
  );

  assign tp_data = {stat_q, lane_q};

endmodule

// File: rtl/trace_port_enc_chk.sv
module trace_port_enc_chk #(
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trace_en,
  input logic              retire,
  input logic              redirect,
  input logic              trig,
  input logic [DATA_W-1:0] tp_data,
  input logic              ovf_flag,
  input logic              restart_hit
);

  logic [1:0] st;
  assign st = tp_data[DATA_W-1 -: 2];

  p_seq_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && retire && !redirect) |=> (st == 2'b01));

  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !retire) |=> (st == 2'b00 || st == 2'b11));

  p_tgt_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && retire && redirect) |=> (st == 2'b10));

  p_trig_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && trig && !retire) |=> (st == 2'b11));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(restart_hit));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> (tp_data == '0));

endmodule

bind trace_port_enc trace_port_enc_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trace_en    (trace_en),
  .retire      (retire),
  .redirect    (redirect),
  .trig        (trig),
  .tp_data     (tp_data),
  .ovf_flag    (ovf_flag),
  .restart_hit (restart_hit)
);

// File: tb/test_trace_port_enc.sv
module test_trace_port_enc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic        retire = 1'b0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic        trig = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        tp_clk;
  logic [6:0]  tp_data;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_port_enc i_trace_port_enc (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .retire(retire),
    .redirect(redirect), .redirect_addr(redirect_addr), .trig(trig),
    .ovf_clr(ovf_clr), .tp_clk(tp_clk), .tp_data(tp_data), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected lane value for slot k of a target, written as right shifts.
  function automatic logic [4:0] exp_slot(input logic [31:0] a, input int k);
    if (k < 6) return 5'((a >> (27 - 5*k)) & 32'h1f);
    return {a[1:0], 3'b000};
  endfunction

  // Drive one cycle of inputs, then sample just after the edge that takes them.
  task automatic step(input logic r, input logic d, input logic [31:0] a, input logic t);
    @(negedge clk);
    retire = r; redirect = d; redirect_addr = a; trig = t;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R8 data after reset", 32'(tp_data), 32'h0);
    check("R8 ovf after reset", 32'(ovf_flag), 32'h0);
    @(posedge clk); #1;
    check("R1 tp_clk high phase", 32'(tp_clk), 32'(clk));
    @(negedge clk); #1;
    check("R1 tp_clk low phase", 32'(tp_clk), 32'(clk));
  endtask

  task automatic t_linear;
    logic pat [5] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    foreach (pat[i]) begin
      step(pat[i], 1'b0, 32'h0, 1'b0);
      check(pat[i] ? "R2 seq status" : "R3 stall status",
            32'(tp_data), pat[i] ? 32'h20 : 32'h00);
    end
    step(1'b0, 1'b1, 32'hDEAD_BEEC, 1'b0);
    check("R3 redirect without retire ignored", 32'(tp_data), 32'h00);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R3 no lane after ignored redirect", 32'(tp_data), 32'h00);
  endtask

  task automatic t_target(input logic [31:0] a);
    step(1'b1, 1'b1, a, 1'b0);
    check("R4 target status", 32'(tp_data[6:5]), 32'h2);
    check("R4 slot 0", 32'(tp_data[4:0]), 32'(exp_slot(a, 0)));
    for (int k = 1; k < 7; k++) begin
      step(1'b1, 1'b0, 32'h0, 1'b0);
      check("R4 seq during serialize", 32'(tp_data[6:5]), 32'h1);
      check("R4 slot", 32'(tp_data[4:0]), 32'(exp_slot(a, k)));
    end
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R4 lane idle after slot 6", 32'(tp_data), 32'h0);
  endtask

  task automatic t_trigger;
    step(1'b1, 1'b0, 32'h0, 1'b1);
    check("R5 completion keeps code with trig", 32'(tp_data[6:5]), 32'h1);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R5 marker still deferred", 32'(tp_data[6:5]), 32'h1);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R5 deferred marker", 32'(tp_data[6:5]), 32'h3);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R5 marker sent once", 32'(tp_data[6:5]), 32'h0);
    step(1'b0, 1'b0, 32'h0, 1'b1);
    check("R5 immediate marker", 32'(tp_data[6:5]), 32'h3);
  endtask

  task automatic t_overflow;
    logic [31:0] a = 32'h1234_5678, b = 32'hCAFE_F00C, c = 32'h8000_0004;
    step(1'b1, 1'b1, a, 1'b0);
    for (int k = 1; k < 7; k++) step(1'b0, 1'b0, 32'h0, 1'b0);
    step(1'b1, 1'b1, b, 1'b0);
    check("R6 seven-cycle spacing no overflow", 32'(ovf_flag), 32'h0);
    check("R6 new target slot 0", 32'(tp_data[4:0]), 32'(exp_slot(b, 0)));
    step(1'b0, 1'b0, 32'h0, 1'b0);
    step(1'b1, 1'b1, c, 1'b0);
    check("R6 overlap sets overflow", 32'(ovf_flag), 32'h1);
    check("R6 restart slot 0", 32'(tp_data), {25'h0, 2'b10, exp_slot(c, 0)});
    for (int k = 1; k < 7; k++) begin
      step(1'b0, 1'b0, 32'h0, 1'b0);
      check("R6 restarted slot", 32'(tp_data[4:0]), 32'(exp_slot(c, k)));
    end
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R6 overflow sticky", 32'(ovf_flag), 32'h1);
    @(negedge clk); ovf_clr = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R6 overflow cleared", 32'(ovf_flag), 32'h0);
  endtask

  task automatic t_disable;
    step(1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b1);
    @(negedge clk); trace_en = 1'b0;
    step(1'b1, 1'b1, 32'h4444_4444, 1'b1);
    check("R7 blank while disabled", 32'(tp_data), 32'h0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R7 blank with completion", 32'(tp_data), 32'h0);
    @(negedge clk); trace_en = 1'b1;
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R7 serialization and marker dropped", 32'(tp_data), 32'h0);
    check("R1 tp_clk while enabled", 32'(tp_clk), 32'(clk));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1; trace_en = 1'b1;
    t_linear();
    t_target(32'hA5C3_0F1E);
    t_target(32'h0000_0004);
    t_trigger();
    t_overflow();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule